// File: doc/BRIEF.md
# Oversampling DPLL Bit Recovery

This block recovers the bit clock and NRZI-decoded data from the hard-limited output of a tone demodulator. It samples its serial input once every few time units. The time unit is a one-cycle `tick` strobe, so the block works at any system clock rate. Every second or third sample is a decision sample. On a decision sample the block looks at where the most recent input transitions fell, and it stretches or shortens the next sample interval by one unit. This moves its sampling phase toward the centre of the data bits.

Decision samples are NRZI-decoded and collected into 16-bit words. Each word is handed downstream with a one-cycle valid strobe. The recent transition history is exported for a carrier detector. A signed, saturating count of timing corrections is also exported for observation. `fine_mode` selects between two timing schemes. With three samples per bit, the nominal interval is 4 units. With two samples per bit, the nominal interval is 6 units.

Top module: `dpll_bit_recovery`

## Requirements
- R1: After a synchronous reset, `bit_stb`, `word_valid`, `trans_hist` and `corr_count` are all zero. The first sample is taken on the tick that ends a nominal interval for the mode applied during reset.
- R2: The interval counter advances only on cycles with `tick` high. Without ticks no sample is taken, so `trans_hist`, `bit_stb` and `corr_count` do not change, whatever `rx_in` does.
- R3: With `fine_mode`=1, the sample phase cycles through decision, intermediate, intermediate. Samples are 4 ticks apart unless a correction applies, so a steady input gives one `bit_stb` every 12 ticks.
- R4: With `fine_mode`=1, the interval that follows a decision sample is 5 ticks when the newest three history bits (newest at bit 0) are 001, and 3 ticks when they are 100.
- R5: With `fine_mode`=0, the phase alternates between decision and intermediate and the nominal interval is 6 ticks. After a decision the interval is 7 ticks when the newest two history bits are 01, and 5 ticks when they are 10.
- R6: Every sample shifts `trans_hist` left by one. The new bit 0 is 1 when the current input differs from the previous sample. Before the first sample, the previous sample counts as 0.
- R7: On a decision sample the decoded bit is 1 when the input equals the input at the previous decision sample, and 0 otherwise. The value before the first decision counts as 0.
- R8: Every 16 decoded bits, `word_valid` pulses for one cycle, together with that bit's `bit_stb`. The first decoded bit of the group is in `word_data` bit 0 and the last is in bit 15. `word_data` holds its value between pulses.
- R9: `corr_count` rises by 1 on each stretched (late) decision interval and falls by 1 on each shortened (early) one. It saturates at its signed limits.
- R10: All outputs are registered and change on the clock edge at which the sample is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-unit strobe |
| rx_in | input | 1 | Hard-limited demodulator output |
| fine_mode | input | 1 | 1: three samples per bit, 0: two samples per bit |
| bit_stb | output | 1 | Recovered bit clock, one cycle per decision sample |
| word_data | output | WORD_W (16) | Packed decoded bits, first bit in bit 0 |
| word_valid | output | 1 | One-cycle strobe for a new word |
| trans_hist | output | HIST_W (8) | Transition history, newest at bit 0 |
| corr_count | output | CORR_W (8) | Signed, saturating late-minus-early correction count |

## Verification
A wrong interval or phase state shows at the ports as a shifted `bit_stb`. A bad correction moves the next bit strobe by one cycle within a single bit period (11 to 13 ticks) and leaves a wrong step in `corr_count`. A corrupted history register shows on `trans_hist` at the very next sample. Because that history also steers the corrections, the error later shifts the bit timing as well. An NRZI or packing fault stays hidden until the next `word_valid`, up to 16 bit periods later. It then shows as a wrong bit value or a wrong bit order in `word_data`. The bench compares every output on every cycle with a model built from the requirements. It also measures the bit spacing under inputs built to force late, early and neutral corrections in both modes.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  typedef enum logic [1:0] {
    CORR_NONE  = 2'd0,
    CORR_LATE  = 2'd1,
    CORR_EARLY = 2'd2
  } corr_kind_e;
endpackage

// File: rtl/dpll_interval_timer.sv
module dpll_interval_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] init_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic             sample_stb
);
  logic [CNT_W-1:0] cnt_q;

  assign sample_stb = tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= init_val;
    end else if (sample_stb) begin
      cnt_q <= reload_val;
    end else if (tick) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R2: the countdown only moves on time-unit strobes
  a_r2_count_holds: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));

  // R3: a remaining interval of zero would stall sampling
  a_r3_count_nonzero: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> cnt_q != '0);
endmodule

// File: rtl/dpll_phase_ctrl.sv
module dpll_phase_ctrl
  import dpll_pkg::*;
#(
  parameter int HIST_W     = 8,
  parameter int CNT_W      = 4,
  parameter int CORR_W     = 8,
  parameter int NOM_FINE   = 4,
  parameter int NOM_COARSE = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sample_stb,
  input  logic                     rx_in,
  input  logic                     fine_mode,
  output logic                     is_decision,
  output logic [CNT_W-1:0]         reload_val,
  output logic [HIST_W-1:0]        hist_q,
  output logic signed [CORR_W-1:0] corr_q
);
  localparam logic [CNT_W-1:0] NF = CNT_W'(NOM_FINE);
  localparam logic [CNT_W-1:0] NC = CNT_W'(NOM_COARSE);
  localparam logic signed [CORR_W-1:0] CMAX = {1'b0, {(CORR_W-1){1'b1}}};
  localparam logic signed [CORR_W-1:0] CMIN = {1'b1, {(CORR_W-1){1'b0}}};

  logic [1:0]        phase_q;
  logic              last_s_q;
  logic [HIST_W-1:0] hist_nxt;
  logic [CNT_W-1:0]  nominal;
  corr_kind_e        kind;

  assign is_decision = (phase_q == 2'd0);
  assign hist_nxt    = {hist_q[HIST_W-2:0], rx_in ^ last_s_q};
  assign nominal     = fine_mode ? NF : NC;

  always_comb begin
    kind = CORR_NONE;
    if (is_decision) begin
      if (fine_mode) begin
        if (hist_nxt[2:0] == 3'b001)      kind = CORR_LATE;
        else if (hist_nxt[2:0] == 3'b100) kind = CORR_EARLY;
      end else begin
        if (hist_nxt[1:0] == 2'b01)       kind = CORR_LATE;
        else if (hist_nxt[1:0] == 2'b10)  kind = CORR_EARLY;
      end
    end
    case (kind)
      CORR_LATE:  reload_val = nominal + CNT_W'(1);
      CORR_EARLY: reload_val = nominal - CNT_W'(1);
      default:    reload_val = nominal;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= 2'd0;
      last_s_q <= 1'b0;
      hist_q   <= '0;
      corr_q   <= '0;
    end else if (sample_stb) begin
      last_s_q <= rx_in;
      hist_q   <= hist_nxt;
      if ((fine_mode && phase_q == 2'd2) || (!fine_mode && phase_q != 2'd0))
        phase_q <= 2'd0;
      else
        phase_q <= phase_q + 2'd1;
      if (kind == CORR_LATE && corr_q != CMAX)
        corr_q <= corr_q + CORR_W'(1);
      else if (kind == CORR_EARLY && corr_q != CMIN)
        corr_q <= corr_q - CORR_W'(1);
    end
  end

  // R6: each sample shifts the history one place
  a_r6_hist_shift: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));

  // R2: history is frozen between samples
  a_r2_hist_hold: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |=> $stable(hist_q));

  // R3: the phase never leaves its three-state range
  a_r3_phase_range: assert property (@(posedge clk) disable iff (rst)
    phase_q != 2'd3);

  // R5: a coarse-mode sample leaves the phase at 0 or 1
  a_r5_coarse_phase: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && !fine_mode) |=> phase_q <= 2'd1);

  // R9: the correction count moves by at most one per sample
  a_r9_corr_step: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |=> $stable(corr_q));
endmodule

// File: rtl/dpll_nrzi_packer.sv
module dpll_nrzi_packer #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              decision,
  input  logic              rx_in,
  output logic              bit_stb,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid
);
  localparam logic [WORD_W:0] SR_INIT = {1'b1, {WORD_W{1'b0}}};

  logic            last_dec_q;
  logic [WORD_W:0] sr_q;
  logic [WORD_W:0] sr_shift;
  logic            dec_bit;

  assign dec_bit  = (rx_in == last_dec_q);
  assign sr_shift = {dec_bit, sr_q[WORD_W:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      last_dec_q <= 1'b0;
      sr_q       <= SR_INIT;
      word_data  <= '0;
      word_valid <= 1'b0;
      bit_stb    <= 1'b0;
    end else begin
      bit_stb    <= decision;
      word_valid <= 1'b0;
      if (decision) begin
        last_dec_q <= rx_in;
        if (sr_shift[0]) begin
          word_data  <= sr_shift[WORD_W:1];
          word_valid <= 1'b1;
          sr_q       <= SR_INIT;
        end else begin
          sr_q <= sr_shift;
        end
      end
    end
  end

  // R8: a word is only delivered alongside a recovered bit
  a_r8_valid_with_bit: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> bit_stb);

  // R8: the word register is stable outside delivery cycles
  a_r8_word_hold: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> $stable(word_data));
endmodule

// File: rtl/dpll_bit_recovery.sv
module dpll_bit_recovery #(
  parameter int WORD_W     = 16,
  parameter int HIST_W     = 8,
  parameter int CORR_W     = 8,
  parameter int NOM_FINE   = 4,
  parameter int NOM_COARSE = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick,
  input  logic                     rx_in,
  input  logic                     fine_mode,
  output logic                     bit_stb,
  output logic [WORD_W-1:0]        word_data,
  output logic                     word_valid,
  output logic [HIST_W-1:0]        trans_hist,
  output logic signed [CORR_W-1:0] corr_count
);
  localparam int NOM_MAX = (NOM_FINE > NOM_COARSE) ? NOM_FINE : NOM_COARSE;
  localparam int CNT_W   = $clog2(NOM_MAX + 2);

  logic             sample_stb;
  logic             is_decision;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] init_val;

  assign init_val = fine_mode ? CNT_W'(NOM_FINE) : CNT_W'(NOM_COARSE);

  dpll_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .init_val   (init_val),
    .reload_val (reload_val),
    .sample_stb (sample_stb)
  );

  dpll_phase_ctrl #(
    .HIST_W     (HIST_W),
    .CNT_W      (CNT_W),
    .CORR_W     (CORR_W),
    .NOM_FINE   (NOM_FINE),
    .NOM_COARSE (NOM_COARSE)
  ) u_phase (
    .clk         (clk),
    .rst         (rst),
    .sample_stb  (sample_stb),
    .rx_in       (rx_in),
    .fine_mode   (fine_mode),
    .is_decision (is_decision),
    .reload_val  (reload_val),
    .hist_q      (trans_hist),
    .corr_q      (corr_count)
  );

  dpll_nrzi_packer #(.WORD_W(WORD_W)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .decision   (sample_stb && is_decision),
    .rx_in      (rx_in),
    .bit_stb    (bit_stb),
    .word_data  (word_data),
    .word_valid (word_valid)
  );

  // R2: no time unit, no recovered bit on the next cycle
  a_r2_tick_gates_bit: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !bit_stb);

  // R9: correction count only changes on an edge that also emits a bit
  a_r9_corr_on_bit: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |-> $stable(corr_count) || $past(rst));
endmodule

// File: tb/dpll_bit_recovery_tb.sv
`timescale 1ns/1ps
module dpll_bit_recovery_tb;
  localparam int W  = 16;
  localparam int HW = 8;
  localparam int CW = 4;

  logic clk = 0;
  logic rst = 1;
  logic tick = 0;
  logic rx_in = 0;
  logic fine_mode = 1;
  logic bit_stb, word_valid;
  logic [W-1:0] word_data;
  logic [HW-1:0] trans_hist;
  logic signed [CW-1:0] corr_count;

  always #2 clk = ~clk;

  dpll_bit_recovery #(.WORD_W(W), .HIST_W(HW), .CORR_W(CW)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .rx_in(rx_in), .fine_mode(fine_mode),
    .bit_stb(bit_stb), .word_data(word_data), .word_valid(word_valid),
    .trans_hist(trans_hist), .corr_count(corr_count));

  int errors = 0, checks = 0;
  bit done = 0;

  // reference state, built from the requirements
  int m_cnt, m_phase, m_corr;
  bit m_last, m_lastdec, m_bit, m_valid;
  logic [HW-1:0] m_hist;
  logic [W:0] m_sr;
  logic [W-1:0] m_word;
  int stepno = 0, last_bit_step = 0, spacing = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (step %0d)", tag, act, exp, stepno);
    end
  endtask

  task automatic model_reset();
    m_cnt = fine_mode ? 4 : 6;
    m_phase = 0; m_corr = 0; m_last = 0; m_lastdec = 0;
    m_bit = 0; m_valid = 0; m_hist = '0; m_sr = 17'h10000; m_word = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; tick = 0;
    @(negedge clk);
    @(negedge clk); rst = 0;
    model_reset();
  endtask

  task automatic step(input bit tk, input bit r);
    bit trans, dec, late, early;
    logic [HW-1:0] hn;
    int nom, ivl;
    @(negedge clk);
    tick = tk; rx_in = r;
    m_bit = 0; m_valid = 0;
    if (tk && m_cnt == 1) begin
      trans = (r != m_last);
      hn = {m_hist[HW-2:0], trans};
      dec = (m_phase == 0);
      nom = fine_mode ? 4 : 6;
      late = 0; early = 0;
      if (dec) begin
        if (fine_mode) begin late = (hn[2:0] == 3'b001); early = (hn[2:0] == 3'b100); end
        else begin late = (hn[1:0] == 2'b01); early = (hn[1:0] == 2'b10); end
      end
      ivl = nom + (late ? 1 : 0) - (early ? 1 : 0);
      if (late && m_corr < 7) m_corr++;
      if (early && m_corr > -8) m_corr--;
      if (dec) begin
        m_bit = 1;
        m_sr = {(r == m_lastdec), m_sr[W:1]};
        m_lastdec = r;
        if (m_sr[0]) begin m_word = m_sr[W:1]; m_valid = 1; m_sr = 17'h10000; end
      end
      if (fine_mode) m_phase = (m_phase == 2) ? 0 : m_phase + 1;
      else m_phase = (m_phase != 0) ? 0 : 1;
      m_last = r; m_hist = hn; m_cnt = ivl;
    end else if (tk) begin
      m_cnt--;
    end
    @(posedge clk); #1;
    stepno++;
    chk(fine_mode ? "R3 bit_stb" : "R5 bit_stb", int'(bit_stb), int'(m_bit));
    chk("R6 trans_hist", int'(trans_hist), int'(m_hist));
    chk("R9 corr_count", int'(corr_count), m_corr);
    chk("R8 word_valid", int'(word_valid), int'(m_valid));
    if (m_valid) chk("R7 word_data", int'(word_data), int'(m_word));
    if (bit_stb) begin spacing = stepno - last_bit_step; last_bit_step = stepno; end
  endtask

  // toggles rx at the sample of the chosen phase, every tick
  task automatic toggle_run(int tphase, int n);
    bit r;
    for (int i = 0; i < n; i++) begin
      r = rx_in;
      if (m_cnt == 1 && m_phase == tphase) r = ~r;
      step(1, r);
    end
  endtask

  task automatic random_run(int n, int tick_pct);
    bit r;
    r = rx_in;
    for (int i = 0; i < n; i++) begin
      if (($urandom % 100) < 12) r = ~r;
      step((($urandom % 100) < tick_pct), r);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [HW-1:0] h0;
    logic [W-1:0] wexp;
    // R1: reset state
    fine_mode = 1;
    do_reset();
    #1;
    chk("R1 bit_stb", int'(bit_stb), 0);
    chk("R1 word_valid", int'(word_valid), 0);
    chk("R1 trans_hist", int'(trans_hist), 0);
    chk("R1 corr_count", int'(corr_count), 0);
    // R1/R3: first sample after four ticks, a decision
    step(1, 1); step(1, 1); step(1, 1);
    chk("R1 no early sample", int'(bit_stb), 0);
    step(1, 1);
    chk("R1 first sample", int'(bit_stb), 1);
    chk("R6 first transition", int'(trans_hist), 1);

    // R8/R7: steady input decodes to all ones, first word after 16 bits
    for (int i = 0; i < 16 * 12; i++) step(1, 1);
    chk("R3 steady spacing", spacing, 12);
    wexp = 16'hFFFF; // first bit was a 0 (0->1 change), then fifteen 1s
    wexp[0] = 1'b0;
    chk("R8 first word order", int'(word_data), int'(wexp));

    // R3/R4/R6/R7/R8/R9: random fine-mode input with sparse ticks
    random_run(4000, 75);

    // R2: no ticks, rx busy, nothing may move
    h0 = trans_hist;
    for (int i = 0; i < 60; i++) step(0, i[0]);
    chk("R2 hist frozen", int'(trans_hist), int'(h0));
    chk("R2 no bit strobe", int'(bit_stb), 0);

    // R4/R9: late corrections in fine mode, then early ones
    do_reset();
    toggle_run(0, 300);
    chk("R4 late spacing", spacing, 13);
    chk("R9 saturate high", int'(corr_count), 7);
    toggle_run(1, 400);
    chk("R4 early spacing", spacing, 11);
    chk("R9 saturate low", int'(corr_count), -8);

    // R5: coarse mode, nominal, late, early, random
    fine_mode = 0;
    do_reset();
    for (int i = 0; i < 60; i++) step(1, 0);
    chk("R5 nominal spacing", spacing, 12);
    toggle_run(0, 300);
    chk("R5 late spacing", spacing, 13);
    chk("R9 coarse high", int'(corr_count), 7);
    toggle_run(1, 400);
    chk("R5 early spacing", spacing, 11);
    chk("R9 coarse low", int'(corr_count), -8);
    random_run(4000, 80);

    // R10: mode switch mid-stream, all ticks
    fine_mode = 1;
    random_run(2000, 100);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule